// File: doc/BRIEF.md
# Serial Memory Byte Address Sequencer

This block produces the byte-array address for each data byte of a serial memory transaction. The protocol engine ahead of it decodes commands and moves bits across the lanes. When the address phase of a transaction is complete, the engine pulses a load strobe with the start address. After that it pulses a byte strobe once for every whole data byte it transfers. The sequencer presents the current array address and, for write transactions, a write strobe in the same cycle as the byte strobe. It advances the address on the clock edge that ends that cycle.

An 8-bit mode register holds the access mode in its top two bits. The mode selects one of three ways of moving through the array. Word mode touches one byte per transaction. Page mode stays inside an aligned 32-byte page and wraps within it. Burst mode walks the whole 128 KiB array and wraps from the top address back to zero. Bit 0 of the register is a flag that is stored for the protocol engine's use. The mode is captured when the address is loaded, so a mode register write during a transaction affects only the next one. Deasserting chip select ends the transaction.

Top module: `byte_addr_seq`

## Requirements
- R1: After reset `mode_q` reads 0x40 (burst, flag bit 0 clear) and `arr_we` is low.
- R2: A `mode_we` pulse stores `mode_wdata[7:6]` into `mode_q[7:6]` and `mode_wdata[0]` into `mode_q[0]`, visible the next cycle; `mode_q[5:1]` always read 0.
- R3: `addr_load` while `cs_n` is low makes `arr_addr` equal `load_addr` in the next cycle and starts a transaction using mode field `mode_q[7:6]` as it was in the load cycle.
- R4: With mode field 01 (burst), each `byte_done` of an active transaction raises `arr_addr` by one in the next cycle, wrapping from 0x1FFFF to 0x00000.
- R5: With mode field 10 (page), each `byte_done` increments `arr_addr[4:0]` modulo 32 while `arr_addr[16:5]` stays unchanged, so 0xNNN1F steps to 0xNNN00.
- R6: With mode field 00 (word), `arr_addr` never moves, and only the first `byte_done` of the transaction can raise `arr_write`... the write strobe `arr_we`.
- R7: Mode field 11 behaves exactly as burst mode.
- R8: `arr_we` is high in the same cycle as `byte_done` only when `wr_txn` is high, a transaction is active, `cs_n` is low and `addr_load` is low; read transactions (`wr_txn` low) never raise it.
- R9: While `cs_n` is high, and after it until the next `addr_load`, `byte_done` neither raises `arr_we` nor changes `arr_addr`.
- R10: A mode write during an active transaction does not change that transaction's stepping; it takes effect from the next `addr_load`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low; high ends the transaction |
| addr_load | input | 1 | Address phase complete, load start address |
| load_addr | input | 17 | Start byte address |
| byte_done | input | 1 | One whole data byte transferred this cycle |
| wr_txn | input | 1 | Current transaction is a write |
| mode_we | input | 1 | Mode register write strobe |
| mode_wdata | input | 8 | Mode register write data |
| mode_q | output | 8 | Mode register contents |
| arr_addr | output | 17 | Current byte array address |
| arr_we | output | 1 | Byte array write strobe |

## Verification
The bench drives burst transfers across 0x1FFFF. A design that carries into a nonexistent bit 17, or stops at the top, shows a wrong address there. It drives page transfers across a page's last byte, where a design that carries into bit 5 leaves the page. Word transactions with several byte strobes check that the address does not move and that only the first byte writes. The bench also checks that the reserved encoding acts as burst, that mode writes during a transaction leave that transaction's stepping unchanged, and that byte strobes after chip select rises neither write nor move the address. Random transactions with random modes, start addresses near the page and array edges, and random lengths are compared against a bench model.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic [1:0] {
    AM_WORD  = 2'd0,
    AM_PAGE  = 2'd1,
    AM_BURST = 2'd2
  } access_mode_e;

  // Mode field decode: 00 word, 10 page, 01 and 11 burst
  function automatic access_mode_e decode_mode(input logic [1:0] fld);
    case (fld)
      2'b00:   return AM_WORD;
      2'b10:   return AM_PAGE;
      default: return AM_BURST;
    endcase
  endfunction
endpackage

// File: rtl/seq_mode_reg.sv
module seq_mode_reg #(
  parameter int MODE_W = 8,
  parameter logic [MODE_W-1:0] RESET_VAL = 8'h40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [MODE_W-1:0] wr_data,
  output logic [MODE_W-1:0] q
);
  localparam int FLD_HI = MODE_W - 1;
  localparam int FLD_LO = MODE_W - 2;

  function automatic logic [MODE_W-1:0] keep_defined(input logic [MODE_W-1:0] d);
    logic [MODE_W-1:0] r;
    r = '0;
    r[FLD_HI:FLD_LO] = d[FLD_HI:FLD_LO];
    r[0] = d[0];
    return r;
  endfunction

  logic [MODE_W-1:0] q_r;
  logic [MODE_W-1:0] rsvd_unused;
  assign rsvd_unused = wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q_r <= RESET_VAL;
    else if (wr_en) q_r <= keep_defined(wr_data);
  end
  assign q = q_r;

  // R2
  mode_field_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (q[FLD_HI:FLD_LO] == $past(wr_data[FLD_HI:FLD_LO])) && (q[0] == $past(wr_data[0])));
endmodule

// File: rtl/seq_txn_ctrl.sv
module seq_txn_ctrl
  import seq_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs_n,
  input  logic         addr_load,
  input  logic         byte_done,
  input  logic         wr_txn,
  input  logic [1:0]   mode_fld,
  output logic         load_en,
  output logic         adv_en,
  output logic         we,
  output access_mode_e tmode
);
  logic         active_q;
  logic         spent_q;
  access_mode_e tmode_q;
  logic         live;
  logic         byte_ev;

  assign load_en = !cs_n && addr_load;
  assign live    = !cs_n && active_q && !addr_load;
  assign byte_ev = live && byte_done;
  assign adv_en  = byte_ev && (tmode_q != AM_WORD);
  assign we      = byte_ev && wr_txn && !(tmode_q == AM_WORD && spent_q);
  assign tmode   = tmode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      spent_q  <= 1'b0;
      tmode_q  <= AM_BURST;
    end else if (cs_n) begin
      active_q <= 1'b0;
    end else if (addr_load) begin
      active_q <= 1'b1;
      spent_q  <= 1'b0;
      tmode_q  <= decode_mode(mode_fld);
    end else if (byte_ev) begin
      spent_q  <= 1'b1;
    end
  end

  // R9
  cs_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (!we && !adv_en));
  // R6
  word_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && tmode_q == AM_WORD) |=> !we);
  // R10
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !load_en) |=> $stable(tmode_q));
endmodule

// File: rtl/seq_addr_ptr.sv
module seq_addr_ptr
  import seq_pkg::*;
#(
  parameter int ADDR_W     = 17,
  parameter int PAGE_BYTES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              adv_en,
  input  access_mode_e      tmode,
  output logic [ADDR_W-1:0] addr
);
  localparam int PAGE_W = $clog2(PAGE_BYTES);

  function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a,
                                                  input access_mode_e m);
    logic [ADDR_W-1:0] inc;
    inc = a + ADDR_W'(1);
    case (m)
      AM_WORD: return a;
      AM_PAGE: return {a[ADDR_W-1:PAGE_W], inc[PAGE_W-1:0]};
      default: return inc;
    endcase
  endfunction

  logic [ADDR_W-1:0] a_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       a_q <= '0;
    else if (load_en) a_q <= load_addr;
    else if (adv_en)  a_q <= step_addr(a_q, tmode);
  end
  assign addr = a_q;

  // R3
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (a_q == $past(load_addr)));
  // R4
  burst_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_en && !load_en && tmode == AM_BURST && a_q == '1) |=> (a_q == '0));
  // R5
  page_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_en && !load_en && tmode == AM_PAGE && a_q[PAGE_W-1:0] == '1)
      |=> (a_q[PAGE_W-1:0] == '0) && $stable(a_q[ADDR_W-1:PAGE_W]));
  // R6
  word_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && tmode == AM_WORD) |=> $stable(a_q));
endmodule

// File: rtl/byte_addr_seq.sv
module byte_addr_seq
  import seq_pkg::*;
#(
  parameter int ADDR_W     = 17,
  parameter int PAGE_BYTES = 32,
  parameter int MODE_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              addr_load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              byte_done,
  input  logic              wr_txn,
  input  logic              mode_we,
  input  logic [MODE_W-1:0] mode_wdata,
  output logic [MODE_W-1:0] mode_q,
  output logic [ADDR_W-1:0] arr_addr,
  output logic              arr_we
);
  logic         load_en;
  logic         adv_en;
  access_mode_e tmode;

  seq_mode_reg #(.MODE_W(MODE_W), .RESET_VAL(MODE_W'(8'h40))) u_mode (
    .clk(clk), .rst_n(rst_n), .wr_en(mode_we), .wr_data(mode_wdata), .q(mode_q));

  seq_txn_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .addr_load(addr_load),
    .byte_done(byte_done), .wr_txn(wr_txn), .mode_fld(mode_q[MODE_W-1:MODE_W-2]),
    .load_en(load_en), .adv_en(adv_en), .we(arr_we), .tmode(tmode));

  seq_addr_ptr #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_ptr (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_addr(load_addr),
    .adv_en(adv_en), .tmode(tmode), .addr(arr_addr));

  // R8
  read_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> (wr_txn && byte_done && !addr_load));
endmodule

// File: tb/byte_addr_seq_bench.sv
module byte_addr_seq_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        addr_load = 1'b0;
  logic [16:0] load_addr = '0;
  logic        byte_done = 1'b0;
  logic        wr_txn = 1'b0;
  logic        mode_we = 1'b0;
  logic [7:0]  mode_wdata = '0;
  logic [7:0]  mode_q;
  logic [16:0] arr_addr;
  logic        arr_we;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // bench model
  logic [7:0]  m_mode = 8'h40;
  logic [16:0] m_addr = '0;
  logic [1:0]  m_tfld = 2'b01;
  bit          m_active = 1'b0;
  bit          m_spent = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  byte_addr_seq u_byte_addr_seq (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .addr_load(addr_load),
    .load_addr(load_addr), .byte_done(byte_done), .wr_txn(wr_txn),
    .mode_we(mode_we), .mode_wdata(mode_wdata), .mode_q(mode_q),
    .arr_addr(arr_addr), .arr_we(arr_we));

  function automatic logic [16:0] next_of(input logic [16:0] a, input logic [1:0] f);
    if (f == 2'b00) return a;
    if (f == 2'b10) return (a & 17'h1FFE0) | ((a + 17'd1) % 17'd32);
    return (a == 17'h1FFFF) ? 17'h0 : a + 17'd1;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input string req, input bit cs, input bit ld, input logic [16:0] la,
                     input bit bd, input bit wr, input bit mwe, input logic [7:0] mwd);
    bit exp_we;
    @(negedge clk);
    chk({req, " addr"}, 32'(arr_addr), 32'(m_addr));
    chk({req, " mode"}, 32'(mode_q), 32'(m_mode));
    cs_n = cs; addr_load = ld; load_addr = la; byte_done = bd;
    wr_txn = wr; mode_we = mwe; mode_wdata = mwd;
    #1;
    exp_we = !cs && !ld && m_active && bd && wr && !(m_tfld == 2'b00 && m_spent);
    chk({req, " we"}, 32'(arr_we), 32'(exp_we));
    if (cs) m_active = 1'b0;
    else if (ld) begin
      m_active = 1'b1; m_spent = 1'b0; m_addr = la; m_tfld = m_mode[7:6];
    end else if (m_active && bd) begin
      m_spent = 1'b1;
      m_addr = next_of(m_addr, m_tfld);
    end
    if (mwe) m_mode = {mwd[7:6], 5'b0, mwd[0]};
  endtask

  task automatic set_mode(input logic [7:0] v);
    cyc("R2", 1'b1, 1'b0, '0, 1'b0, 1'b0, 1'b1, v);
  endtask

  task automatic txn(input string req, input logic [16:0] start, input int n, input bit wr);
    cyc(req, 1'b0, 1'b1, start, 1'b0, wr, 1'b0, 8'h0);
    for (int i = 0; i < n; i++) cyc(req, 1'b0, 1'b0, '0, 1'b1, wr, 1'b0, 8'h0);
    cyc(req, 1'b1, 1'b0, '0, 1'b0, 1'b0, 1'b0, 8'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 mode", 32'(mode_q), 32'h40);
    chk("R1 we", 32'(arr_we), 32'h0);
    rst_n = 1'b1;
    // R2 reserved bits read zero
    set_mode(8'hFF);
    set_mode(8'h40);
    // R4 burst wrap across top, R3 load
    txn("R4", 17'h1FFFD, 6, 1'b1);
    // R5 page wrap
    set_mode(8'h80);
    txn("R5", 17'h0ABDE, 5, 1'b1);
    txn("R5", 17'h1FFFF, 3, 1'b0);
    // R6 word mode
    set_mode(8'h00);
    txn("R6", 17'h01234, 4, 1'b1);
    // R7 reserved encoding as burst
    set_mode(8'hC0);
    txn("R7", 17'h1FFFE, 4, 1'b1);
    // R8 read never writes
    set_mode(8'h40);
    txn("R8", 17'h00100, 3, 1'b0);
    // R9 cs high then byte strobes ignored
    cyc("R9", 1'b0, 1'b1, 17'h00500, 1'b0, 1'b1, 1'b0, 8'h0);
    cyc("R9", 1'b0, 1'b0, '0, 1'b1, 1'b1, 1'b0, 8'h0);
    cyc("R9", 1'b1, 1'b0, '0, 1'b1, 1'b1, 1'b0, 8'h0);
    cyc("R9", 1'b0, 1'b0, '0, 1'b1, 1'b1, 1'b0, 8'h0);
    cyc("R9", 1'b0, 1'b0, '0, 1'b1, 1'b1, 1'b0, 8'h0);
    cyc("R9", 1'b1, 1'b0, '0, 1'b0, 1'b0, 1'b0, 8'h0);
    // R10 mode write mid-transaction
    cyc("R10", 1'b0, 1'b1, 17'h0003E, 1'b0, 1'b1, 1'b0, 8'h0);
    cyc("R10", 1'b0, 1'b0, '0, 1'b1, 1'b1, 1'b1, 8'h00);
    cyc("R10", 1'b0, 1'b0, '0, 1'b1, 1'b1, 1'b0, 8'h0);
    cyc("R10", 1'b0, 1'b0, '0, 1'b1, 1'b1, 1'b0, 8'h0);
    cyc("R10", 1'b1, 1'b0, '0, 1'b0, 1'b0, 1'b0, 8'h0);
    txn("R10", 17'h0003E, 3, 1'b1);
    // random transactions
    for (int t = 0; t < 400; t++) begin
      logic [16:0] st;
      logic [7:0]  mv;
      mv = 8'($urandom);
      set_mode(mv);
      case ($urandom % 4)
        0: st = 17'h1FFFF - 17'($urandom % 4);
        1: st = {12'($urandom), 5'h1F} - 17'($urandom % 3);
        default: st = 17'($urandom);
      endcase
      txn("R4/R5/R6/R7/R8", st, int'($urandom % 40), 1'($urandom));
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule